// File: doc/BRIEF.md
# Typed configuration register bank

A flat bank of 32-bit configuration words. Each word has its own access type, fixed at build time: plain read/write, read/write that survives hot reset, read-only, read-only that survives hot reset, loaded-once-then-locked, and status words that hardware sets and software clears by writing ones. The set can be sticky or plain. There is also a control word that software sets through its own address and clears through a paired clear address. Software reaches the bank through a simple register port. Each write is masked per byte lane. A read returns its data one clock after the read strobe.

Hardware raises status bits through a per-bit set vector. A preload port stands in for an external configuration memory and can overwrite any stored word, but only during the window that follows a fundamental reset. The window stays open until the init-done input is seen. Two resets act on the bank. The asynchronous fundamental reset restores every word to its default. The synchronous hot reset restores only the words that are not sticky.

Top module: `cfg_reg_bank`

## Requirements
- R1: The default map is: word 0 read/write (default 0x000000A5), word 1 sticky read/write (0x00001234), word 2 read-only (0x0000C0DE), word 3 sticky read-only (0x00000F0F), word 4 load-once (0x11112222), word 5 status (0), word 6 sticky status (0), word 7 set-control (0), word 8 clear alias of word 7, words 9 to 15 unmapped. Fundamental reset (rst_ni low) returns every word to its default, clears rd_data_o and opens the preload window.
- R2: A software write to a read/write or sticky read/write word replaces only the byte lanes whose be_i bit is 1, where be_i[k] selects bits 8k+7:8k.
- R3: Software writes never change a read-only, sticky read-only or load-once word.
- R4: In a status word, a 1 on hw_set_i (bit 32·w+b for word w, bit b) sets bit b. A software write clears the enabled bits written as 1 and leaves bits written as 0 unchanged.
- R5: When hardware sets a status bit in the same cycle that software writes 1 to clear it, the bit ends up 1.
- R6: A write of 1 to an enabled bit at word 7 sets that bit. A write of 1 at word 8 clears the same bit of word 7. Writes of 0 at either address change nothing, and a read of word 8 returns word 7.
- R7: While the preload window is open, ld_i writes ld_data_i whole into the stored word at ld_addr_i. A load aimed at the clear alias or at an unmapped address changes nothing.
- R8: Once init_done_i has been sampled high, loads are ignored until the next fundamental reset.
- R9: A hot_rst_i cycle returns words 0, 2, 5 and 7 to their defaults and leaves words 1, 3, 4 and 6 unchanged. The hot reset takes priority over a software write in the same cycle.
- R10: Reads of unmapped addresses return zero, and writes to them change no word.
- R11: rd_data_o takes the addressed value on the clock edge that samples rd_i high and holds it while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Fundamental reset, asynchronous, active low |
| hot_rst_i | input | 1 | Hot reset, synchronous, active high |
| addr_i | input | AW | Software word address |
| wdata_i | input | DW | Software write data |
| be_i | input | DW/8 | Byte lane enables for writes |
| we_i | input | 1 | Software write strobe |
| rd_i | input | 1 | Software read strobe |
| rd_data_o | output | DW | Registered read data |
| hw_set_i | input | NREG·DW | Per-bit status set from hardware |
| ld_i | input | 1 | Preload strobe |
| ld_addr_i | input | AW | Preload word address |
| ld_data_i | input | DW | Preload data |
| init_done_i | input | 1 | Closes the preload window |

## Verification
The bench walks every address through all sixteen byte-enable patterns and checks each readback against a model built from the access rules. A design that ignored the lane enables, let writes reach locked words or alias the wrong word would show up there. It collides a hardware set with a software clear on both status words. A clear-wins design would lose the event. It checks that loads are refused after init-done and accepted again after a fresh fundamental reset, which catches a window that never closes or never reopens. A hot reset is issued together with a write, and the bench expects the non-sticky words back at their defaults and the sticky words untouched. Any swap in stickiness shows there.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  typedef enum logic [3:0] {
    ACC_RW,
    ACC_RWS,
    ACC_RO,
    ACC_ROS,
    ACC_HWINIT,
    ACC_RW1C,
    ACC_RW1CS,
    ACC_W1S,
    ACC_W1S_CLR
  } acc_e;

  localparam int DEF_NREG = 9;

  localparam acc_e DEF_ACC [DEF_NREG] = '{
    ACC_RW, ACC_RWS, ACC_RO, ACC_ROS, ACC_HWINIT,
    ACC_RW1C, ACC_RW1CS, ACC_W1S, ACC_W1S_CLR
  };

  localparam logic [31:0] DEF_RST [DEF_NREG] = '{
    32'h0000_00A5, 32'h0000_1234, 32'h0000_C0DE, 32'h0000_0F0F,
    32'h1111_2222, 32'h0, 32'h0, 32'h0, 32'h0
  };

endpackage

// File: rtl/cfg_init_win.sv
module cfg_init_win #(
  parameter int AW   = 4,
  parameter int NREG = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_done_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_ok_o
);

  logic win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          win_q <= 1'b1;
    else if (init_done_i) win_q <= 1'b0;
  end

  assign ld_ok_o = win_q && ld_i && ({1'b0, ld_addr_i} < (AW+1)'(NREG));

endmodule

// File: rtl/cfg_field.sv
module cfg_field
  import cfg_bank_pkg::*;
#(
  parameter int            DW  = 32,
  parameter acc_e          ACC = ACC_RW,
  parameter logic [DW-1:0] RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hot_rst_i,
  input  logic          sw_we_i,
  input  logic          clr_we_i,
  input  logic [DW-1:0] wmask_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [DW-1:0] hw_set_i,
  output logic [DW-1:0] q_o
);

  localparam bit STICKY = (ACC == ACC_RWS) || (ACC == ACC_ROS) ||
                          (ACC == ACC_HWINIT) || (ACC == ACC_RW1CS);
  localparam bit STATUS = (ACC == ACC_RW1C) || (ACC == ACC_RW1CS);
  localparam bit STORED = (ACC != ACC_W1S_CLR);

  logic [DW-1:0] q, nxt, wbits;

  assign wbits = wdata_i & wmask_i;

  always_comb begin
    nxt = q;
    case (ACC)
      ACC_RW, ACC_RWS: if (sw_we_i) nxt = (q & ~wmask_i) | wbits;
      ACC_RW1C, ACC_RW1CS: if (sw_we_i) nxt = q & ~wbits;
      ACC_W1S: begin
        if (sw_we_i)  nxt = q | wbits;
        if (clr_we_i) nxt = nxt & ~wbits;
      end
      default: ;
    endcase
    if (ld_i && STORED) nxt = ld_data_i;
    // hardware event outranks clear and load
    if (STATUS) nxt = nxt | hw_set_i;
    if (hot_rst_i && !STICKY) nxt = RST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST;
    else         q <= nxt;
  end

  assign q_o = q;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_bank_pkg::*;
#(
  parameter int            NREG       = DEF_NREG,
  parameter int            DW         = 32,
  parameter int            AW         = 4,
  parameter acc_e          ACC [NREG] = DEF_ACC,
  parameter logic [DW-1:0] RST [NREG] = DEF_RST
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hot_rst_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW/8-1:0]    be_i,
  input  logic               we_i,
  input  logic               rd_i,
  output logic [DW-1:0]      rd_data_o,
  input  logic [NREG*DW-1:0] hw_set_i,
  input  logic               ld_i,
  input  logic [AW-1:0]      ld_addr_i,
  input  logic [DW-1:0]      ld_data_i,
  input  logic               init_done_i
);

  localparam int BW = DW / 8;

  logic [DW-1:0]      wmask;
  logic [NREG*DW-1:0] q_flat;
  logic [NREG*DW-1:0] rd_flat;
  logic [NREG-1:0]    sw_we, clr_we, ld_we;
  logic               ld_ok;

  for (genvar b = 0; b < BW; b++) begin : g_mask
    assign wmask[b*8 +: 8] = {8{be_i[b]}};
  end

  cfg_init_win #(.AW(AW), .NREG(NREG)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (init_done_i),
    .ld_i        (ld_i),
    .ld_addr_i   (ld_addr_i),
    .ld_ok_o     (ld_ok)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_fld
    assign sw_we[i] = we_i && (addr_i == AW'(i));
    assign ld_we[i] = ld_ok && (ld_addr_i == AW'(i));

    if (i + 1 < NREG && ACC[i+1] == ACC_W1S_CLR) begin : g_pair
      assign clr_we[i] = we_i && (addr_i == AW'(i + 1));
    end else begin : g_nopair
      assign clr_we[i] = 1'b0;
    end

    if (ACC[i] == ACC_W1S_CLR && i > 0) begin : g_alias
      assign rd_flat[i*DW +: DW] = q_flat[(i-1)*DW +: DW];
    end else begin : g_own
      assign rd_flat[i*DW +: DW] = q_flat[i*DW +: DW];
    end

    cfg_field #(.DW(DW), .ACC(ACC[i]), .RST(RST[i])) u_fld (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hot_rst_i (hot_rst_i),
      .sw_we_i   (sw_we[i]),
      .clr_we_i  (clr_we[i]),
      .wmask_i   (wmask),
      .wdata_i   (wdata_i),
      .ld_i      (ld_we[i]),
      .ld_data_i (ld_data_i),
      .hw_set_i  (hw_set_i[i*DW +: DW]),
      .q_o       (q_flat[i*DW +: DW])
    );
  end

  logic [DW-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NREG; i++)
      if (addr_i == AW'(i)) rd_sel = rd_flat[i*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= rd_sel;
  end

endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int            NREG       = DEF_NREG,
  parameter int            DW         = 32,
  parameter int            AW         = 4,
  parameter acc_e          ACC [NREG] = DEF_ACC,
  parameter logic [DW-1:0] RST [NREG] = DEF_RST
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hot_rst_i,
  input logic               rd_i,
  input logic [AW-1:0]      addr_i,
  input logic [DW-1:0]      rd_data_o,
  input logic [NREG*DW-1:0] hw_set_i,
  input logic [NREG-1:0]    ld_we,
  input logic [NREG*DW-1:0] q_flat
);

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    if (ACC[i] == ACC_RO || ACC[i] == ACC_ROS || ACC[i] == ACC_HWINIT) begin : g_ro
      // R3
      ro_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_we[i] && !(hot_rst_i && ACC[i] == ACC_RO))
        |=> $stable(q_flat[i*DW +: DW]));
    end

    if (ACC[i] == ACC_RW1C || ACC[i] == ACC_RW1CS) begin : g_st
      // R5
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|hw_set_i[i*DW +: DW]) && !(hot_rst_i && ACC[i] == ACC_RW1C))
        |=> ((q_flat[i*DW +: DW] & $past(hw_set_i[i*DW +: DW]))
             == $past(hw_set_i[i*DW +: DW])));
    end

    if (ACC[i] == ACC_RW || ACC[i] == ACC_RO || ACC[i] == ACC_RW1C ||
        ACC[i] == ACC_W1S) begin : g_hot
      // R9
      hot_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hot_rst_i |=> (q_flat[i*DW +: DW] == RST[i]));
    end
  end

  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ({1'b0, addr_i} >= (AW+1)'(NREG))) |=> (rd_data_o == '0));

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));

endmodule

bind cfg_reg_bank cfg_bank_chk #(
  .NREG(NREG), .DW(DW), .AW(AW), .ACC(ACC), .RST(RST)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hot_rst_i (hot_rst_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .hw_set_i  (hw_set_i),
  .ld_we     (ld_we),
  .q_flat    (q_flat)
);

// File: tb/cfg_reg_bank_test.sv
module cfg_reg_bank_test;

  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         hot_rst_i = 1'b0;
  logic [3:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [3:0]   be_i = '0;
  logic         we_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [31:0]  rd_data_o;
  logic [287:0] hw_set_i = '0;
  logic         ld_i = 1'b0;
  logic [3:0]   ld_addr_i = '0;
  logic [31:0]  ld_data_i = '0;
  logic         init_done_i = 1'b0;

  int total = 0;
  int bad = 0;
  logic [31:0] m [9];

  always #(CLK_P/2) clk = ~clk;

  cfg_reg_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .hot_rst_i(hot_rst_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .we_i(we_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .hw_set_i(hw_set_i), .ld_i(ld_i),
    .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i), .init_done_i(init_done_i)
  );

  function automatic logic [31:0] dflt(int a);
    case (a)
      0: return 32'h0000_00A5;
      1: return 32'h0000_1234;
      2: return 32'h0000_C0DE;
      3: return 32'h0000_0F0F;
      4: return 32'h1111_2222;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    if (a < 8)  return m[a];
    if (a == 8) return m[7];
    return 32'h0;
  endfunction

  function automatic string tag_of(int a);
    if (a < 2) return "R2";
    if (a < 5) return "R3";
    if (a < 7) return "R4";
    if (a < 9) return "R6";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic mdl_wr(int a, logic [31:0] d, logic [3:0] be);
    logic [31:0] mk, w;
    for (int b = 0; b < 4; b++) mk[b*8 +: 8] = {8{be[b]}};
    w = d & mk;
    case (a)
      0, 1: m[a] = (m[a] & ~mk) | w;
      5, 6: m[a] = m[a] & ~w;
      7:    m[7] = m[7] | w;
      8:    m[7] = m[7] & ~w;
      default: ;
    endcase
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be);
    addr_i = 4'(a); wdata_i = d; be_i = be; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
    mdl_wr(a, d, be);
  endtask

  task automatic rd_chk(int a, string tag);
    addr_i = 4'(a); rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    chk(tag, rd_data_o, exp_rd(a));
  endtask

  task automatic chk_all(string tag);
    for (int a = 0; a < 16; a++) rd_chk(a, tag);
  endtask

  task automatic ld(int a, logic [31:0] d);
    ld_addr_i = 4'(a); ld_data_i = d; ld_i = 1'b1;
    @(negedge clk);
    ld_i = 1'b0;
  endtask

  task automatic hw_set(int w, logic [31:0] bits);
    hw_set_i[w*32 +: 32] = bits;
    @(negedge clk);
    hw_set_i = '0;
    m[w] = m[w] | bits;
  endtask

  task automatic fund_reset;
    rst_ni = 1'b0;
    for (int i = 0; i < 9; i++) m[i] = dflt(i);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    fund_reset();
    // R1 reset map
    chk("R1", rd_data_o, 32'h0);
    chk_all("R1");

    // R7 preload inside window
    for (int a = 0; a < 16; a++) begin
      logic [31:0] d;
      d = 32'h5A00_0000 | (32'(a) * 32'h0001_0101);
      ld(a, d);
      if (a < 8) m[a] = d;
    end
    chk_all("R7");

    // R8 window closes
    init_done_i = 1'b1;
    @(negedge clk);
    init_done_i = 1'b0;
    for (int a = 0; a < 9; a++) ld(a, 32'hDEAD_0000 | 32'(a));
    chk_all("R8");

    // R2 R3 R4 R6 R10 sweep over addresses and lane enables
    for (int a = 0; a < 16; a++) begin
      hw_set(5, 32'hF0F0_00FF);
      hw_set(6, 32'h0F0F_FF00);
      for (int be = 0; be < 16; be++) begin
        logic [31:0] d;
        d = 32'hA5C3_3C5A ^ (32'(a) * 32'h0101_0101) ^ (32'(be) * 32'h1111_1111);
        wr(a, d, 4'(be));
        rd_chk(a, tag_of(a));
        if (a == 7) rd_chk(8, "R6");
        if (a == 8) rd_chk(7, "R6");
      end
    end
    chk_all("R10");

    // R6 zero writes have no effect
    wr(7, 32'h0000_00F0, 4'hF);
    wr(7, 32'h0, 4'hF);
    wr(8, 32'h0, 4'hF);
    rd_chk(7, "R6");
    wr(8, 32'h0000_0030, 4'hF);
    rd_chk(8, "R6");

    // R5 set beats clear in the same cycle
    hw_set(5, 32'h0000_0008);
    hw_set(6, 32'h0000_0200);
    hw_set_i[5*32 +: 32] = 32'h0000_0008;
    hw_set_i[6*32 +: 32] = 32'h0000_0200;
    addr_i = 4'd5; wdata_i = 32'hFFFF_FFFF; be_i = 4'hF; we_i = 1'b1;
    @(negedge clk);
    addr_i = 4'd6;
    @(negedge clk);
    we_i = 1'b0; hw_set_i = '0;
    m[5] = 32'h0000_0008;
    m[6] = 32'h0000_0200;
    rd_chk(5, "R5");
    rd_chk(6, "R5");

    // R11 read data holds while strobe is low
    rd_chk(0, "R11");
    addr_i = 4'd2;
    repeat (3) @(negedge clk);
    chk("R11", rd_data_o, m[0]);

    // R9 hot reset with a write in the same cycle
    hw_set(5, 32'h0000_0F00);
    hw_set(6, 32'h00F0_0000);
    wr(7, 32'h0000_0C00, 4'hF);
    wr(1, 32'h7777_8888, 4'hF);
    hot_rst_i = 1'b1;
    addr_i = 4'd0; wdata_i = 32'h1234_5678; be_i = 4'hF; we_i = 1'b1;
    @(negedge clk);
    hot_rst_i = 1'b0; we_i = 1'b0;
    m[0] = dflt(0); m[2] = dflt(2); m[5] = dflt(5); m[7] = dflt(7);
    chk_all("R9");

    // R1 fundamental reset restores all and reopens window
    fund_reset();
    chk_all("R1");
    ld(4, 32'h4444_5555);
    m[4] = 32'h4444_5555;
    rd_chk(4, "R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule